// File: doc/BRIEF.md
# Packed Lane Media ALU

This block performs lane-parallel arithmetic on two 32-bit words. Each word is read as four independent bytes or as two independent halfwords, and no carry or borrow ever leaves a lane. A 3-bit operation code picks one of six media-style operations: per-byte absolute difference, unsigned byte average, signed halfword average, per-byte bit count, byte swap inside each halfword, and four unsigned 8x8 multiplies.

The block has two result channels. The five single-cycle operations write a 32-bit result one clock after issue. The quad multiply passes through a four-stage pipe and writes a 64-bit result holding four 16-bit products. Because the channels are separate, a new operation can be issued on every clock. A multiply issued three cycles before a single-cycle operation completes on the same edge as that operation.

Top module: `simd_lane_alu`

## Requirements
- R1: While reset is held, and on the first edge after it, `res_valid` and `mul_valid` are low and `res` and `mul_res` read zero.
- R2: Opcode 0 (absolute difference) sets result byte i to |a byte i − b byte i|, with both bytes unsigned.
- R3: Opcode 1 (byte average) sets result byte i to (a byte i + b byte i + 1) >> 1, unsigned, computed without overflow (0xFF and 0xFF give 0xFF).
- R4: Opcode 2 (halfword average) sets result halfword h to (a half h + b half h + 1) >> 1, two's-complement, arithmetic shift (0x8000 and 0x8000 give 0x8000; 0xFFFF and 0x0000 give 0x0000).
- R5: Opcode 3 (bit count) sets result byte i to the number of ones in a byte i, from 0 to 8. The value of b is ignored.
- R6: Opcode 4 (byte swap) returns a with bytes 0 and 1 exchanged and bytes 2 and 3 exchanged. The value of b is ignored.
- R7: Opcode 5 (quad multiply) places the unsigned product of a byte i and b byte i in `mul_res` bits 16i+15 down to 16i.
- R8: For opcodes 0 to 4, `res_valid` pulses and `res` carries the result exactly one edge after the edge that samples `in_valid`.
- R9: For opcode 5, `mul_valid` pulses exactly four edges after issue, with the product on `mul_res`. It does not depend on what is issued in the cycles between, and it may coincide with a pulse on `res_valid`.
- R10: Opcodes 6 and 7, and any cycle with `in_valid` low, produce no pulse on either channel. Opcode 5 produces no pulse on `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Issue an operation this cycle |
| op | input | 3 | Operation code |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| res_valid | output | 1 | Single-cycle result present |
| res | output | 32 | Single-cycle result |
| mul_valid | output | 1 | Quad product present |
| mul_res | output | 64 | Four 16-bit products |

## Verification
A completing quad multiply and a single-cycle result can appear on the same edge. The bench provokes this directly: it issues a multiply and, three cycles later, an absolute difference. It also reaches the same overlap through long runs of random issue in which every opcode, including the reserved ones, is mixed back to back. A behavioural model keeps a separate expected slot for each channel, and on every clock both channels are compared at once. A mix-up between the pipes, or a dropped or shifted pulse, therefore appears as a mismatch on one channel in exactly the cycle where the two meet.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  op,
  input  logic [31:0] a,
  input  logic [31:0] b,
  output logic        res_valid,
  output logic [31:0] res,
  output logic        mul_valid,
  output logic [63:0] mul_res
);
  localparam logic [2:0] OP_ABSD = 3'd0;
  localparam logic [2:0] OP_AVGU = 3'd1;
  localparam logic [2:0] OP_AVGS = 3'd2;
  localparam logic [2:0] OP_POPC = 3'd3;
  localparam logic [2:0] OP_SWAP = 3'd4;
  localparam logic [2:0] OP_MUL  = 3'd5;
  localparam int MUL_LAT = 4;

  logic [31:0] alu_c;
  logic [63:0] prod_c;
  logic        hit_alu, hit_mul;
  logic [63:0] mpipe [MUL_LAT];
  logic [MUL_LAT-1:0] mvld;

  assign hit_alu = in_valid && (op <= OP_SWAP);
  assign hit_mul = in_valid && (op == OP_MUL);

  always_comb begin
    logic [8:0]         s9;
    logic signed [16:0] s17;
    logic [3:0]         cnt;
    alu_c = '0;
    s9    = '0;
    s17   = '0;
    cnt   = '0;
    case (op)
      OP_ABSD:
        for (int i = 0; i < 4; i++)
          alu_c[8*i +: 8] = (a[8*i +: 8] > b[8*i +: 8]) ? a[8*i +: 8] - b[8*i +: 8]
                                                        : b[8*i +: 8] - a[8*i +: 8];
      OP_AVGU:
        for (int i = 0; i < 4; i++) begin
          s9 = {1'b0, a[8*i +: 8]} + {1'b0, b[8*i +: 8]} + 9'd1;
          alu_c[8*i +: 8] = s9[8:1];
        end
      OP_AVGS:
        for (int h = 0; h < 2; h++) begin
          s17 = {a[16*h+15], a[16*h +: 16]} + {b[16*h+15], b[16*h +: 16]} + 17'sd1;
          alu_c[16*h +: 16] = s17[16:1];
        end
      OP_POPC:
        for (int i = 0; i < 4; i++) begin
          cnt = '0;
          for (int k = 0; k < 8; k++) cnt = cnt + {3'd0, a[8*i+k]};
          alu_c[8*i +: 8] = {4'd0, cnt};
        end
      OP_SWAP: alu_c = {a[23:16], a[31:24], a[7:0], a[15:8]};
      default: alu_c = '0;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_prod
      assign prod_c[16*g +: 16] = {8'd0, a[8*g +: 8]} * {8'd0, b[8*g +: 8]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= '0;
      mvld      <= '0;
      for (int s = 0; s < MUL_LAT; s++) mpipe[s] <= '0;
    end else begin
      res_valid <= hit_alu;
      if (hit_alu) res <= alu_c;
      mvld     <= {mvld[MUL_LAT-2:0], hit_mul};
      mpipe[0] <= hit_mul ? prod_c : mpipe[0];
      for (int s = 1; s < MUL_LAT; s++) mpipe[s] <= mpipe[s-1];
    end
  end

  assign mul_valid = mvld[MUL_LAT-1];
  assign mul_res   = mpipe[MUL_LAT-1];
endmodule

module simd_lane_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic [31:0] a,
  input logic [31:0] b,
  input logic        res_valid,
  input logic [31:0] res,
  input logic        mul_valid,
  input logic [63:0] mul_res
);
  AST_ALU_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op <= 3'd4) |=> res_valid); // R8
  AST_MUL_FOUR_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd5) |-> ##4 mul_valid); // R9
  AST_MUL_HAS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    mul_valid |-> ($past(in_valid, 4) && $past(op, 4) == 3'd5)); // R9
  AST_NO_RES_ON_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || op >= 3'd5) |=> !res_valid); // R10
  AST_ABSD_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd0 && a == b) |=> res == 32'd0); // R2
  AST_POPC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(op) == 3'd3) |->
      (res[7:0] <= 8'd8 && res[15:8] <= 8'd8 && res[23:16] <= 8'd8 && res[31:24] <= 8'd8)); // R5
  AST_MUL_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd5 && a == 32'd0) |-> ##4 (mul_res == 64'd0)); // R7
endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (.*);

// File: tb/simd_lane_alu_bench.sv
`timescale 1ns/1ps
module simd_lane_alu_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [31:0] a = '0, b = '0;
  logic res_valid, mul_valid;
  logic [31:0] res;
  logic [63:0] mul_res;

  int n_cmp = 0, n_bad = 0;

  bit          r_v;
  logic [31:0] r_d;
  int          r_op;
  bit          m_v [4];
  logic [63:0] m_d [4];

  always #10 clk = ~clk;

  simd_lane_alu u_simd_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .res_valid(res_valid), .res(res), .mul_valid(mul_valid), .mul_res(mul_res));

  function automatic string tag_of(int code);
    case (code)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [31:0] ref_alu(int code, logic [31:0] x, logic [31:0] y);
    logic [31:0] r = '0;
    int p, q, s;
    for (int i = 0; i < 4; i++) begin
      p = int'(x[8*i +: 8]);
      q = int'(y[8*i +: 8]);
      case (code)
        0: s = (p > q) ? p - q : q - p;
        1: s = (p + q + 1) / 2;
        3: s = $countones(x[8*i +: 8]);
        default: s = 0;
      endcase
      r[8*i +: 8] = s[7:0];
    end
    if (code == 2)
      for (int h = 0; h < 2; h++) begin
        p = int'($signed(x[16*h +: 16]));
        q = int'($signed(y[16*h +: 16]));
        s = (p + q + 1) >>> 1;
        r[16*h +: 16] = s[15:0];
      end
    if (code == 4) r = {x[23:16], x[31:24], x[7:0], x[15:8]};
    return r;
  endfunction

  function automatic logic [63:0] ref_mul(logic [31:0] x, logic [31:0] y);
    logic [63:0] r;
    int s;
    for (int i = 0; i < 4; i++) begin
      s = int'(x[8*i +: 8]) * int'(y[8*i +: 8]);
      r[16*i +: 16] = s[15:0];
    end
    return r;
  endfunction

  task automatic compare();
    n_cmp++;
    if (res_valid !== r_v) begin
      n_bad++;
      $display("FAIL %s res_valid actual %0b expected %0b", r_v ? "R8" : "R10", res_valid, r_v);
    end else if (r_v && res !== r_d) begin
      n_bad++;
      $display("FAIL %s res actual %h expected %h", tag_of(r_op), res, r_d);
    end
    n_cmp++;
    if (mul_valid !== m_v[3]) begin
      n_bad++;
      $display("FAIL %s mul_valid actual %0b expected %0b", m_v[3] ? "R9" : "R10", mul_valid, m_v[3]);
    end else if (m_v[3] && mul_res !== m_d[3]) begin
      n_bad++;
      $display("FAIL R7 mul_res actual %h expected %h", mul_res, m_d[3]);
    end
  endtask

  task automatic step(bit v, int code, logic [31:0] x, logic [31:0] y);
    @(negedge clk);
    compare();
    for (int s = 3; s > 0; s--) begin m_v[s] = m_v[s-1]; m_d[s] = m_d[s-1]; end
    m_v[0] = v && code == 5;
    m_d[0] = ref_mul(x, y);
    r_v  = v && code <= 4;
    r_op = code;
    if (r_v) r_d = ref_alu(code, x, y);
    in_valid = v; op = 3'(code); a = x; b = y;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    r_v = 0; r_d = '0; r_op = 0;
    for (int s = 0; s < 4; s++) begin m_v[s] = 0; m_d[s] = '0; end
    repeat (3) @(negedge clk);
    n_cmp++;
    if (res_valid !== 1'b0 || mul_valid !== 1'b0 || res !== '0 || mul_res !== '0) begin
      n_bad++;
      $display("FAIL R1 reset outputs actual %b%b %h %h expected 00 zero", res_valid, mul_valid, res, mul_res);
    end
    rst_n = 1'b1;
    // directed corners
    step(1, 0, 32'hFF00_1080, 32'h00FF_8010); // R2
    step(1, 0, 32'h1234_5678, 32'h1234_5678); // R2
    step(1, 1, 32'hFFFF_0001, 32'hFF00_0000); // R3
    step(1, 2, 32'h8000_7FFF, 32'h8000_7FFF); // R4
    step(1, 2, 32'hFFFF_FFFF, 32'h0000_FFFE); // R4
    step(1, 3, 32'hFF00_0F81, 32'hDEAD_BEEF); // R5
    step(1, 4, 32'h1122_3344, 32'hFFFF_FFFF); // R6
    step(1, 5, 32'hFF01_80FF, 32'hFF02_80FF); // R7
    step(1, 6, 32'h1, 32'h2);                 // R10
    step(1, 7, 32'h3, 32'h4);                 // R10
    step(0, 0, 32'h5, 32'h6);                 // R10
    // collision: multiply then single-cycle op three cycles later, R9
    step(1, 5, 32'h0203_0405, 32'h0607_0809);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(1, 0, 32'h0A0B_0C0D, 32'h0D0C_0B0A);
    step(1, 5, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 5, 32'h0, 32'h1234_5678);
    step(1, 3, 32'hFFFF_FFFF, 32'h0);
    step(1, 1, 32'h0102_0304, 32'h0203_0405);
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, int'($urandom % 8), $urandom, $urandom);
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule